// File: doc/BRIEF.md
# Flyback Protection and Auto-Restart Sequencer

This block sits between the analog fault comparators of an offline flyback controller and its gate driver. It gathers the fault bits, qualifies each with its own debounce rule, and when one is confirmed it removes gate drive and walks the supply through a restart sequence. Some faults are qualified by elapsed clock time and others by consecutive switching cycles. The supply itself is seen through three level flags: turn-on, turn-off (UVLO) and high-voltage-start.

Two restart flavours exist. The plain restart keeps the gate off until the supply has sagged to the high-voltage start level, then lets the startup source recharge it to turn-on. The extended restart is used for output under-voltage. It lets the supply sag and recharge a set number of times with no switching and with a reduced-current request raised, then resumes switching. The state machine has five states. ST_START charges from the high-voltage source. ST_RUN allows switching. ST_AR_WAIT is the plain-restart sag. ST_EXT_FALL and ST_EXT_RISE form one extended lap. Transitions: START→RUN on turn-on; RUN→AR_WAIT on any non-under-voltage fault or UVLO; RUN→EXT_FALL on a confirmed under-voltage; AR_WAIT→START on the high-voltage start level; EXT_FALL→EXT_RISE on the high-voltage start level; EXT_RISE→EXT_FALL on turn-on while laps remain; EXT_RISE→RUN on turn-on at the last lap.

Top module: `prot_seq`

## Requirements
- R1: After reset the block is in ST_START with hv_en_o=1, gate_en_o=0 and low_iq_o=0. It moves to ST_RUN (gate_en_o=1, hv_en_o=0, low_iq_o=0) on the clock edge at which vdd_on_i is high.
- R2: In ST_RUN, vdd_ovp_i high on OVP_TICKS consecutive clocks causes a plain restart. A shorter burst has no effect, and any low clock restarts the count.
- R3: In ST_RUN, line_low_i high on BO_TICKS consecutive clocks causes a plain restart. A shorter burst has no effect.
- R4: vs_ovp_i seen high on CYC_N consecutive cyc_stb_i strobes causes a plain restart. A strobe with the bit low clears the count. Clocks without a strobe change nothing.
- R5: cs_short_i on CYC_N consecutive strobes causes a plain restart, and any clean strobe clears its count. diode_short_i on DIODE_N consecutive strobes (default 1) causes a plain restart.
- R6: otp_i high in ST_RUN causes a plain restart on the next edge.
- R7: vs_uvp_i on CYC_N consecutive strobes enters the extended restart (gate_en_o=0, hv_en_o=0, low_iq_o=1). It is ignored during the first UVP_BLANK_TICKS clocks of each stay in ST_RUN.
- R8: In a plain restart, gate_en_o and hv_en_o stay low until vdd_hv_i is seen high. The block then returns to ST_START.
- R9: The extended restart makes EXT_LAPS laps. Each lap is a fall, waiting for vdd_hv_i, then a rise with hv_en_o=1, waiting for vdd_on_i. low_iq_o stays 1 throughout. On vdd_on_i at the last lap the block returns to ST_RUN with low_iq_o=0.
- R10: When an under-voltage trip and any other trip are confirmed on the same edge, the extended restart is taken.
- R11: For the first SD_START_TICKS clocks of ST_RUN the shutdown check uses sd_low_st_i (the higher startup threshold). After that it uses sd_low_i. A confirmed low lasting SD_TICKS clocks causes a plain restart.
- R12: While switching (burst_off_i=0), the shutdown comparator is sampled only on cyc_stb_i. While burst is stopped (burst_off_i=1) it is sampled every clock.
- R13: vdd_off_i high in ST_RUN removes gate drive on the next edge and enters the plain restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_ovp_i | input | 1 | Supply over-voltage comparator |
| vs_ovp_i | input | 1 | Sampled output over-voltage, valid with cyc_stb_i |
| vs_uvp_i | input | 1 | Sampled output under-voltage, valid with cyc_stb_i |
| line_low_i | input | 1 | Line-sense current below brownout level |
| sd_low_i | input | 1 | Shutdown input below normal threshold |
| sd_low_st_i | input | 1 | Shutdown input below startup threshold |
| otp_i | input | 1 | Over-temperature comparator |
| cs_short_i | input | 1 | Current-sense short, valid with cyc_stb_i |
| diode_short_i | input | 1 | Output diode short, valid with cyc_stb_i |
| cyc_stb_i | input | 1 | One-clock strobe per switching cycle |
| burst_off_i | input | 1 | Burst mode has stopped switching |
| vdd_on_i | input | 1 | Supply at or above turn-on level |
| vdd_off_i | input | 1 | Supply below turn-off level |
| vdd_hv_i | input | 1 | Supply at or below high-voltage start level |
| gate_en_o | output | 1 | Switching permitted |
| hv_en_o | output | 1 | High-voltage startup source enabled |
| low_iq_o | output | 1 | Reduced operating current request |

## Verification
The bench shrinks every time window: OVP_TICKS=8, BO_TICKS=20, SD_TICKS=10, SD_START_TICKS=30 and UVP_BLANK_TICKS=60. It keeps CYC_N=2, DIODE_N=1 and EXT_LAPS=2. With these values the exact trip edge of every debounce, both shutdown thresholds and the end of the under-voltage blanking can be reached in a few dozen cycles. A long random run of over-voltage strobes then checks the consecutive-cycle count at every step.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;
    typedef enum logic [2:0] {
        ST_START    = 3'd0,
        ST_RUN      = 3'd1,
        ST_AR_WAIT  = 3'd2,
        ST_EXT_FALL = 3'd3,
        ST_EXT_RISE = 3'd4
    } seq_state_t;

    localparam int NUM_CYC_FLT = 4;
    localparam int CYC_OVP = 0;
    localparam int CYC_UVP = 1;
    localparam int CYC_CSS = 2;
    localparam int CYC_DSS = 3;
endpackage

// File: rtl/prot_time_deb.sv
module prot_time_deb #(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fault,
    output logic trip
);
    localparam int W = $clog2(TICKS + 1);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || !fault)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign trip = en && fault && (cnt == LAST);
endmodule

// File: rtl/prot_cyc_deb.sv
module prot_cyc_deb #(
    parameter int COUNT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stb,
    input  logic fault,
    output logic trip
);
    localparam int W = $clog2(COUNT + 1);
    localparam logic [W-1:0] LAST = W'(COUNT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en)
            cnt <= '0;
        else if (stb) begin
            if (!fault)
                cnt <= '0;
            else if (cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end

    assign trip = en && stb && fault && (cnt == LAST);
endmodule

// File: rtl/prot_seq.sv
module prot_seq
    import prot_seq_pkg::*;
#(
    parameter int OVP_TICKS       = 7000,
    parameter int BO_TICKS        = 1650000,
    parameter int SD_TICKS        = 40000,
    parameter int SD_START_TICKS  = 100000,
    parameter int UVP_BLANK_TICKS = 4000000,
    parameter int CYC_N           = 2,
    parameter int DIODE_N         = 1,
    parameter int EXT_LAPS        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_ovp_i,
    input  logic vs_ovp_i,
    input  logic vs_uvp_i,
    input  logic line_low_i,
    input  logic sd_low_i,
    input  logic sd_low_st_i,
    input  logic otp_i,
    input  logic cs_short_i,
    input  logic diode_short_i,
    input  logic cyc_stb_i,
    input  logic burst_off_i,
    input  logic vdd_on_i,
    input  logic vdd_off_i,
    input  logic vdd_hv_i,
    output logic gate_en_o,
    output logic hv_en_o,
    output logic low_iq_o
);
    localparam int TMAX = (UVP_BLANK_TICKS > SD_START_TICKS) ? UVP_BLANK_TICKS : SD_START_TICKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int LW   = $clog2(EXT_LAPS + 1);

    seq_state_t state, state_nx;
    logic       running;
    logic [TW-1:0] run_tmr;
    logic [LW-1:0] lap;
    logic       in_sd_window, uvp_armed;
    logic       sd_sel, sd_lvl;
    logic       ovp_trip, bo_trip, sd_trip;
    logic [NUM_CYC_FLT-1:0] cyc_flt, cyc_trip;
    logic       norm_trip, ext_trip;

    assign running = (state == ST_RUN);

    // Time since entering the switching state, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_tmr <= '0;
        else if (!running)
            run_tmr <= '0;
        else if (run_tmr != TW'(TMAX))
            run_tmr <= run_tmr + 1'b1;
    end

    assign in_sd_window = run_tmr < TW'(SD_START_TICKS);
    assign uvp_armed    = run_tmr >= TW'(UVP_BLANK_TICKS);

    // Shutdown comparator sampling: per cycle while switching, continuous in burst-off
    assign sd_sel = in_sd_window ? sd_low_st_i : sd_low_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sd_lvl <= 1'b0;
        else if (!running)
            sd_lvl <= 1'b0;
        else if (burst_off_i || cyc_stb_i)
            sd_lvl <= sd_sel;
    end

    prot_time_deb #(.TICKS(OVP_TICKS)) u_ovp_deb (
        .clk(clk), .rst_n(rst_n), .en(running), .fault(vdd_ovp_i), .trip(ovp_trip));
    prot_time_deb #(.TICKS(BO_TICKS)) u_bo_deb (
        .clk(clk), .rst_n(rst_n), .en(running), .fault(line_low_i), .trip(bo_trip));
    prot_time_deb #(.TICKS(SD_TICKS)) u_sd_deb (
        .clk(clk), .rst_n(rst_n), .en(running), .fault(sd_lvl), .trip(sd_trip));

    // Cycle-count debounces
    always_comb begin
        cyc_flt          = '0;
        cyc_flt[CYC_OVP] = vs_ovp_i;
        cyc_flt[CYC_UVP] = vs_uvp_i && uvp_armed;
        cyc_flt[CYC_CSS] = cs_short_i;
        cyc_flt[CYC_DSS] = diode_short_i;
    end

    for (genvar gi = 0; gi < NUM_CYC_FLT; gi++) begin : g_cyc
        localparam int N = (gi == CYC_DSS) ? DIODE_N : CYC_N;
        prot_cyc_deb #(.COUNT(N)) u_deb (
            .clk(clk), .rst_n(rst_n), .en(running), .stb(cyc_stb_i),
            .fault(cyc_flt[gi]), .trip(cyc_trip[gi]));
    end

    assign ext_trip  = cyc_trip[CYC_UVP];
    assign norm_trip = cyc_trip[CYC_OVP] | cyc_trip[CYC_CSS] | cyc_trip[CYC_DSS]
                     | ovp_trip | bo_trip | sd_trip | otp_i | vdd_off_i;

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_START:    if (vdd_on_i) state_nx = ST_RUN;
            ST_RUN: begin
                if (ext_trip)       state_nx = ST_EXT_FALL;
                else if (norm_trip) state_nx = ST_AR_WAIT;
            end
            ST_AR_WAIT:  if (vdd_hv_i) state_nx = ST_START;
            ST_EXT_FALL: if (vdd_hv_i) state_nx = ST_EXT_RISE;
            ST_EXT_RISE: begin
                if (vdd_on_i)
                    state_nx = (lap == LW'(EXT_LAPS - 1)) ? ST_RUN : ST_EXT_FALL;
            end
            default:     state_nx = ST_START;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_START;
        else        state <= state_nx;
    end

    // Extended-restart lap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lap <= '0;
        else if (running)
            lap <= '0;
        else if (state == ST_EXT_RISE && vdd_on_i)
            lap <= lap + 1'b1;
    end

    // Outputs
    always_comb begin
        gate_en_o = 1'b0;
        hv_en_o   = 1'b0;
        low_iq_o  = 1'b0;
        unique case (state)
            ST_START:    hv_en_o = 1'b1;
            ST_RUN:      gate_en_o = 1'b1;
            ST_AR_WAIT:  ;
            ST_EXT_FALL: low_iq_o = 1'b1;
            ST_EXT_RISE: begin
                hv_en_o  = 1'b1;
                low_iq_o = 1'b1;
            end
            default:     ;
        endcase
    end
endmodule

module prot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic gate_en_o,
    input logic hv_en_o,
    input logic low_iq_o,
    input logic vdd_on_i,
    input logic vdd_hv_i,
    input logic vdd_off_i,
    input logic otp_i
);
    AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en_o |-> (!hv_en_o && !low_iq_o)); // R1

    AST_GATE_NEEDS_TURN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en_o) |-> $past(vdd_on_i)); // R1

    AST_OTP_STOPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && otp_i) |=> !gate_en_o); // R6

    AST_UVLO_STOPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && vdd_off_i) |=> !gate_en_o); // R13

    AST_LOWIQ_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        low_iq_o |-> !gate_en_o); // R9

    AST_RESTART_NEEDS_HV_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hv_en_o) && !low_iq_o) |-> $past(vdd_hv_i)); // R8
endmodule

bind prot_seq prot_seq_chk u_chk (.*);

// File: tb/prot_seq_test.sv
`timescale 1ns/100ps
module prot_seq_test;
    localparam int OVP_T = 8;
    localparam int BO_T  = 20;
    localparam int SD_T  = 10;
    localparam int SD_ST = 30;
    localparam int UVB   = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdd_ovp = 0, vs_ovp = 0, vs_uvp = 0, line_low = 0, sd_low = 0, sd_low_st = 0;
    logic otp = 0, cs_short = 0, diode_short = 0, cyc_stb = 0, burst_off = 0;
    logic vdd_on = 0, vdd_off = 0, vdd_hv = 0;
    logic gate_en, hv_en, low_iq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    prot_seq #(
        .OVP_TICKS(OVP_T), .BO_TICKS(BO_T), .SD_TICKS(SD_T),
        .SD_START_TICKS(SD_ST), .UVP_BLANK_TICKS(UVB),
        .CYC_N(2), .DIODE_N(1), .EXT_LAPS(2)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .vdd_ovp_i(vdd_ovp), .vs_ovp_i(vs_ovp), .vs_uvp_i(vs_uvp),
        .line_low_i(line_low), .sd_low_i(sd_low), .sd_low_st_i(sd_low_st),
        .otp_i(otp), .cs_short_i(cs_short), .diode_short_i(diode_short),
        .cyc_stb_i(cyc_stb), .burst_off_i(burst_off),
        .vdd_on_i(vdd_on), .vdd_off_i(vdd_off), .vdd_hv_i(vdd_hv),
        .gate_en_o(gate_en), .hv_en_o(hv_en), .low_iq_o(low_iq)
    );

    // Expected cycle-count debounce result
    function automatic logic cyc_tripped(int run_len, int need);
        return run_len >= need;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [2:0] exp);
        total++;
        if ({gate_en, hv_en, low_iq} !== exp) begin
            bad++;
            $display("FAIL %s: gate/hv/lowiq actual=%b expected=%b at %0t",
                     req, {gate_en, hv_en, low_iq}, exp, $time);
        end
    endtask

    task automatic strobe(logic o, logic u, logic c, logic d);
        vs_ovp = o; vs_uvp = u; cs_short = c; diode_short = d; cyc_stb = 1'b1;
        tick(1);
        vs_ovp = 0; vs_uvp = 0; cs_short = 0; diode_short = 0; cyc_stb = 1'b0;
    endtask

    task automatic restart_ar();
        vdd_on = 0; vdd_hv = 1;
        tick(1);
        chk("R8 back to start", 3'b010);
        vdd_hv = 0; vdd_on = 1;
        tick(1);
        chk("R1 start to run", 3'b100);
    endtask

    task automatic ext_laps();
        vdd_on = 0; vdd_hv = 1; tick(1);
        chk("R9 lap1 rise", 3'b011);
        vdd_hv = 0; vdd_on = 1; tick(1);
        chk("R9 lap1 done fall", 3'b001);
        vdd_on = 0; vdd_hv = 1; tick(1);
        chk("R9 lap2 rise", 3'b011);
        vdd_hv = 0; vdd_on = 1; tick(1);
        chk("R9 resume run", 3'b100);
    endtask

    initial begin
        int run_len;
        logic b;
        void'($urandom(32'd7331));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset state", 3'b010);
        tick(2);
        chk("R1 waits turn-on", 3'b010);
        vdd_on = 1; tick(1);
        chk("R1 enter run", 3'b100);

        // R7 blanking: under-voltage ignored right after start
        strobe(0, 1, 0, 0); strobe(0, 1, 0, 0); strobe(0, 1, 0, 0);
        chk("R7 uvp blanked", 3'b100);

        // R11 startup threshold, continuous sampling in burst-off (R12)
        burst_off = 1; sd_low_st = 1;
        tick(SD_T);
        chk("R11 startup sd not yet", 3'b100);
        tick(1);
        chk("R11 startup sd trip", 3'b000);
        sd_low_st = 0; burst_off = 0;
        restart_ar();

        // R11 after window the startup comparator is ignored
        tick(40);
        burst_off = 1; sd_low_st = 1; tick(20);
        chk("R11 startup threshold ignored", 3'b100);
        sd_low_st = 0;
        // R12 while switching, no strobe -> no sample
        burst_off = 0; sd_low = 1; tick(20);
        chk("R12 no strobe no sample", 3'b100);
        cyc_stb = 1; tick(1); cyc_stb = 0;
        tick(SD_T - 1);
        chk("R12 sampled sd debouncing", 3'b100);
        tick(1);
        chk("R12 sampled sd trip", 3'b000);
        sd_low = 0;
        restart_ar();

        // R2 supply over-voltage
        vdd_ovp = 1; tick(OVP_T - 1);
        chk("R2 short burst", 3'b100);
        vdd_ovp = 0; tick(1);
        chk("R2 count cleared", 3'b100);
        vdd_ovp = 1; tick(OVP_T - 1);
        chk("R2 one short", 3'b100);
        tick(1);
        chk("R2 trip", 3'b000);
        vdd_ovp = 0;
        restart_ar();

        // R3 brownout
        line_low = 1; tick(BO_T - 1);
        chk("R3 short low line", 3'b100);
        line_low = 0; tick(1);
        line_low = 1; tick(BO_T);
        chk("R3 trip", 3'b000);
        line_low = 0;
        restart_ar();

        // R6 over-temperature
        otp = 1; tick(1); otp = 0;
        chk("R6 otp trip", 3'b000);
        restart_ar();

        // R13 UVLO
        vdd_off = 1; tick(1); vdd_off = 0;
        chk("R13 uvlo stop", 3'b000);
        restart_ar();

        // R5 diode short single cycle
        strobe(0, 0, 0, 1);
        chk("R5 diode trip", 3'b000);
        restart_ar();

        // R5 current-sense short, clean cycle clears count
        strobe(0, 0, 1, 0); chk("R5 cs one", 3'b100);
        strobe(0, 0, 0, 0); chk("R5 cs clean", 3'b100);
        strobe(0, 0, 1, 0); chk("R5 cs after clear", 3'b100);
        strobe(0, 0, 1, 0); chk("R5 cs trip", 3'b000);
        restart_ar();

        // R4 random output over-voltage strobes
        run_len = 0;
        for (int i = 0; i < 80; i++) begin
            b = 1'($urandom % 2);
            strobe(b, 0, 0, 0);
            run_len = b ? run_len + 1 : 0;
            if (cyc_tripped(run_len, 2)) begin
                chk("R4 ovp trip", 3'b000);
                restart_ar();
                run_len = 0;
            end else begin
                chk("R4 ovp hold", 3'b100);
            end
            tick(int'($urandom % 3));
        end

        // R7 armed under-voltage enters extended restart
        tick(UVB + 5);
        strobe(0, 1, 0, 0); chk("R7 uvp one", 3'b100);
        strobe(0, 1, 0, 0); chk("R7 uvp extended", 3'b001);
        ext_laps();

        // R10 priority of under-voltage
        tick(UVB + 5);
        strobe(1, 1, 0, 0); chk("R10 both one", 3'b100);
        strobe(1, 1, 0, 0); chk("R10 extended wins", 3'b001);
        ext_laps();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule